// File: doc/BRIEF.md
# PCI Parity Error Reporting Unit

This block sits beside a PCI-style bus interface that can work as initiator (master) or as responder (target). It checks even parity over the 32 address/data lines and the 4 command/byte-enable lines. The parity bit is taken in the clock that follows each address or data phase. When a check fails, or when another agent reports an error, the block drives the active-low PERR# or SERR# strobes. It also updates sticky bits in a 16-bit status register and in an 8-bit error-detect register, and it can pulse a processor machine-check request.

The role and direction latched with each phase decide the outcome of a failed check. They select which strobe fires and which status bits set. They also decide whether received write data is flagged to be dropped, and whether the address of the transfer is recorded in an error address register.

Software clears bits by writing ones through a clear-mask input. The error address register keeps the first address it captured until its own clear input is pulsed.

Top module: `pci_perr_unit`

## Requirements
- R1: After reset, `perr_n` and `serr_n` are 1, `mcp_req` and `data_drop` are 0, `status` and `err_det` are all zero, and `err_addr_vld` is 0.
- R2: A parity error is found when `par`, sampled in the clock after a phase, differs from the XOR of the 36 `ad`/`cbe` bits of that phase. Status bit 15 then reads 1 two clocks after the phase, whatever the enable inputs are. Address phases are always checked.
- R3: If the unit was target in an address phase that has a parity error, and both `cmd_serr_en` and `cmd_perr_resp` are 1, then `serr_n` is 0 for exactly the clock two after the address phase, and status bit 14 sets at the same time. If either enable is 0, neither happens.
- R4: A data parity error on a master read, with `cmd_perr_resp` at 1, drives `perr_n` to 0 for one clock two clocks after the data phase and sets status bit 8. If `cmd_perr_resp` is 0, neither happens.
- R5: If the last data phase was a master write and `perr_in_n` is 0 in some clock, status bit 15 reads 1 in the next clock. Status bit 8 also sets if `cmd_perr_resp` is 1. The unit's own `perr_n` stays 1.
- R6: A data parity error on a target write sets error-detect bit 6 and pulses `data_drop` for one clock, two clocks after the data phase, whatever the enables are. `perr_n` pulses in the same clock only if `cmd_perr_resp` is 1.
- R7: If the last data phase was a target read and `perr_in_n` is 0 in some clock, and no address is held, then `err_addr` takes the `ad` value of the most recent address phase, and `err_addr_vld` reads 1 in the next clock.
- R8: While `err_addr_vld` is 1, later captures leave `err_addr` unchanged. A pulse on `err_addr_clr` makes `err_addr_vld` 0 in the next clock.
- R9: `serr_in_n` at 0 sets error-detect bit 7 in the next clock only when `serr_rx_en` is 1. Otherwise it has no effect.
- R10: `mcp_req` is a one-clock pulse. It appears in the same clock as a PERR#/SERR# strobe, a status bit 8 set, an address capture event, or a recognised external SERR#, and only if `mcp_en` was 1 when the event was detected. Otherwise it stays 0.
- R11: A 1 in `sts_clr` or `ed_clr` clears the matching bit in the next clock. An error that sets the same bit in the same clock wins over the clear.
- R12: Data that the unit sends is never parity-checked: a bad `par` on a master write or target read data phase sets no status bit and fires no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_phase | input | 1 | Address phase in this clock |
| data_phase | input | 1 | Data phase in this clock |
| ad | input | 32 | Address/data lines |
| cbe | input | 4 | Command/byte-enable lines |
| par | input | 1 | Even parity bit for the previous phase |
| is_master | input | 1 | Unit is initiator of the current transfer |
| is_write | input | 1 | Current transfer is a write |
| perr_in_n | input | 1 | PERR# driven by the other agent |
| serr_in_n | input | 1 | SERR# driven by another agent |
| cmd_perr_resp | input | 1 | Command bit 6: respond to parity errors |
| cmd_serr_en | input | 1 | Command bit 8: SERR# enable |
| mcp_en | input | 1 | Machine-check report enable |
| serr_rx_en | input | 1 | Recognise external SERR# |
| sts_clr | input | 16 | Write-one-to-clear mask for status |
| ed_clr | input | 8 | Write-one-to-clear mask for error-detect |
| err_addr_clr | input | 1 | Release the error address register |
| perr_n | output | 1 | PERR# strobe, active low |
| serr_n | output | 1 | SERR# strobe, active low |
| mcp_req | output | 1 | Machine-check request pulse |
| data_drop | output | 1 | Received write data is to be discarded |
| status | output | 16 | Status register (bits 15, 14, 8 used) |
| err_det | output | 8 | Error-detect register (bits 7, 6 used) |
| err_addr | output | 32 | Captured transfer address |
| err_addr_vld | output | 1 | err_addr holds a capture |

## Verification
A write-one-to-clear of the status register can land in the same clock as a new parity error that sets one of the bits being cleared. The bench provokes this by driving an all-ones `sts_clr` during the clock in which `par` is compared, both in a directed case and at random. It then checks that the newly set bit survives while the other set bits are cleared. The random mix also places PERR#/SERR# reporting and the machine-check pulse under shifting enable settings, and every outcome is checked against a bench model.

// File: rtl/pci_perr_pkg.sv
package pci_perr_pkg;

    localparam int AD_W_DEF = 32;
    localparam int BE_W_DEF = 4;
    localparam int ST_W     = 16;
    localparam int ED_W     = 8;

    // status bit positions (software decodes these)
    localparam int ST_DPE  = 15;
    localparam int ST_SSE  = 14;
    localparam int ST_MDPE = 8;

    // error-detect bit positions
    localparam int ED_TPERR = 6;
    localparam int ED_XSERR = 7;

    // snapshot of one bus phase, held for the parity compare clock
    typedef struct packed {
        logic vld;
        logic par_exp;
        logic master;
    } snap_t;

    function automatic logic par_mismatch(input logic par_in, input snap_t s);
        return s.vld & (par_in ^ s.par_exp);
    endfunction

endpackage

// File: rtl/perr_par_check.sv
module perr_par_check
    import pci_perr_pkg::*;
#(
    parameter int AD_W = AD_W_DEF,
    parameter int BE_W = BE_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            addr_phase,
    input  logic            data_phase,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            par,
    input  logic            is_master,
    input  logic            is_write,
    output logic            a_err,
    output logic            a_as_tgt,
    output logic            d_err_mrd,
    output logic            d_err_twr,
    output logic            last_mst,
    output logic            last_wr,
    output logic [AD_W-1:0] last_addr
);
    snap_t a_q, d_q;
    logic  d_wr_q;
    logic  exp_now;

    assign exp_now = ^{ad, cbe};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q       <= '0;
            d_q       <= '0;
            d_wr_q    <= 1'b0;
            last_addr <= '0;
        end else begin
            a_q.vld <= addr_phase;
            d_q.vld <= data_phase;
            if (addr_phase) begin
                a_q.par_exp <= exp_now;
                a_q.master  <= is_master;
                last_addr   <= ad;
            end
            if (data_phase) begin
                d_q.par_exp <= exp_now;
                d_q.master  <= is_master;
                d_wr_q      <= is_write;
            end
        end
    end

    logic d_bad;
    assign d_bad     = par_mismatch(par, d_q);
    assign a_err     = par_mismatch(par, a_q);
    assign a_as_tgt  = ~a_q.master;
    // only the receiving side checks data parity
    assign d_err_mrd = d_bad & d_q.master & ~d_wr_q;
    assign d_err_twr = d_bad & ~d_q.master & d_wr_q;
    assign last_mst  = d_q.master;
    assign last_wr   = d_wr_q;

    assert_phase_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(addr_phase && data_phase));

    assert_no_tx_check_R12: assert property (@(posedge clk) disable iff (rst)
        (data_phase && (is_master == is_write)) |=> !(d_err_mrd || d_err_twr));

endmodule

// File: rtl/perr_report.sv
module perr_report
    import pci_perr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            a_err,
    input  logic            a_as_tgt,
    input  logic            d_err_mrd,
    input  logic            d_err_twr,
    input  logic            last_mst,
    input  logic            last_wr,
    input  logic            perr_in_n,
    input  logic            serr_in_n,
    input  logic            cmd_perr_resp,
    input  logic            cmd_serr_en,
    input  logic            mcp_en,
    input  logic            serr_rx_en,
    output logic            perr_n,
    output logic            serr_n,
    output logic            mcp_req,
    output logic            data_drop,
    output logic [ST_W-1:0] sts_set,
    output logic [ED_W-1:0] ed_set,
    output logic            log_req
);
    logic serr_fire, perr_fire, mwr_perr, trd_perr, mdpe, xserr, report;

    always_comb begin
        serr_fire = a_err & a_as_tgt & cmd_serr_en & cmd_perr_resp;
        perr_fire = (d_err_mrd | d_err_twr) & cmd_perr_resp;
        mwr_perr  = ~perr_in_n & last_mst & last_wr;
        trd_perr  = ~perr_in_n & ~last_mst & ~last_wr;
        mdpe      = (d_err_mrd | mwr_perr) & cmd_perr_resp;
        xserr     = ~serr_in_n & serr_rx_en;
        report    = serr_fire | perr_fire | mdpe | trd_perr | xserr;

        sts_set          = '0;
        sts_set[ST_DPE]  = a_err | d_err_mrd | d_err_twr | mwr_perr;
        sts_set[ST_SSE]  = serr_fire;
        sts_set[ST_MDPE] = mdpe;

        ed_set           = '0;
        ed_set[ED_TPERR] = d_err_twr;
        ed_set[ED_XSERR] = xserr;

        log_req = trd_perr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_n    <= 1'b1;
            serr_n    <= 1'b1;
            mcp_req   <= 1'b0;
            data_drop <= 1'b0;
        end else begin
            perr_n    <= ~perr_fire;
            serr_n    <= ~serr_fire;
            mcp_req   <= report & mcp_en;
            data_drop <= d_err_twr;
        end
    end

    assert_serr_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !serr_n |-> $past(cmd_serr_en && cmd_perr_resp));

    assert_perr_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(cmd_perr_resp));

    assert_mcp_gate_R10: assert property (@(posedge clk) disable iff (rst)
        mcp_req |-> $past(mcp_en));

    assert_drop_pairs_R6: assert property (@(posedge clk) disable iff (rst)
        (!perr_n && !$past(d_err_mrd)) |-> data_drop);

endmodule

// File: rtl/perr_status_regs.sv
module perr_status_regs
    import pci_perr_pkg::*;
#(
    parameter int AD_W = AD_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] sts_set,
    input  logic [ED_W-1:0] ed_set,
    input  logic [ST_W-1:0] sts_clr,
    input  logic [ED_W-1:0] ed_clr,
    input  logic            log_req,
    input  logic [AD_W-1:0] last_addr,
    input  logic            err_addr_clr,
    output logic [ST_W-1:0] status,
    output logic [ED_W-1:0] err_det,
    output logic [AD_W-1:0] err_addr,
    output logic            err_addr_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status       <= '0;
            err_det      <= '0;
            err_addr     <= '0;
            err_addr_vld <= 1'b0;
        end else begin
            // a new error beats a clear in the same clock
            status  <= (status & ~sts_clr) | sts_set;
            err_det <= (err_det & ~ed_clr) | ed_set;
            if (err_addr_clr) begin
                err_addr_vld <= 1'b0;
            end else if (log_req && !err_addr_vld) begin
                err_addr_vld <= 1'b1;
                err_addr     <= last_addr;
            end
        end
    end

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (status[ST_DPE] && !sts_clr[ST_DPE]) |=> status[ST_DPE]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        sts_set[ST_DPE] |=> status[ST_DPE]);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (err_addr_vld && !err_addr_clr) |=> (err_addr_vld && $stable(err_addr)));

    assert_addr_release_R8: assert property (@(posedge clk) disable iff (rst)
        err_addr_clr |=> !err_addr_vld);

endmodule

// File: rtl/pci_perr_unit.sv
module pci_perr_unit
    import pci_perr_pkg::*;
#(
    parameter int AD_W = AD_W_DEF,
    parameter int BE_W = BE_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            addr_phase,
    input  logic            data_phase,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            par,
    input  logic            is_master,
    input  logic            is_write,
    input  logic            perr_in_n,
    input  logic            serr_in_n,
    input  logic            cmd_perr_resp,
    input  logic            cmd_serr_en,
    input  logic            mcp_en,
    input  logic            serr_rx_en,
    input  logic [ST_W-1:0] sts_clr,
    input  logic [ED_W-1:0] ed_clr,
    input  logic            err_addr_clr,
    output logic            perr_n,
    output logic            serr_n,
    output logic            mcp_req,
    output logic            data_drop,
    output logic [ST_W-1:0] status,
    output logic [ED_W-1:0] err_det,
    output logic [AD_W-1:0] err_addr,
    output logic            err_addr_vld
);
    logic            a_err, a_as_tgt, d_err_mrd, d_err_twr, last_mst, last_wr, log_req;
    logic [AD_W-1:0] last_addr;
    logic [ST_W-1:0] sts_set;
    logic [ED_W-1:0] ed_set;

    perr_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_check (
        .clk(clk), .rst(rst),
        .addr_phase(addr_phase), .data_phase(data_phase),
        .ad(ad), .cbe(cbe), .par(par),
        .is_master(is_master), .is_write(is_write),
        .a_err(a_err), .a_as_tgt(a_as_tgt),
        .d_err_mrd(d_err_mrd), .d_err_twr(d_err_twr),
        .last_mst(last_mst), .last_wr(last_wr), .last_addr(last_addr)
    );

    perr_report u_report (
        .clk(clk), .rst(rst),
        .a_err(a_err), .a_as_tgt(a_as_tgt),
        .d_err_mrd(d_err_mrd), .d_err_twr(d_err_twr),
        .last_mst(last_mst), .last_wr(last_wr),
        .perr_in_n(perr_in_n), .serr_in_n(serr_in_n),
        .cmd_perr_resp(cmd_perr_resp), .cmd_serr_en(cmd_serr_en),
        .mcp_en(mcp_en), .serr_rx_en(serr_rx_en),
        .perr_n(perr_n), .serr_n(serr_n), .mcp_req(mcp_req), .data_drop(data_drop),
        .sts_set(sts_set), .ed_set(ed_set), .log_req(log_req)
    );

    perr_status_regs #(.AD_W(AD_W)) u_regs (
        .clk(clk), .rst(rst),
        .sts_set(sts_set), .ed_set(ed_set),
        .sts_clr(sts_clr), .ed_clr(ed_clr),
        .log_req(log_req), .last_addr(last_addr), .err_addr_clr(err_addr_clr),
        .status(status), .err_det(err_det),
        .err_addr(err_addr), .err_addr_vld(err_addr_vld)
    );

endmodule

// File: tb/pci_perr_unit_tb_top.sv
`timescale 1ns/1ps
module pci_perr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_phase = 0, data_phase = 0, par = 0, is_master = 0, is_write = 0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        perr_in_n = 1, serr_in_n = 1;
    logic        cmd_perr_resp = 0, cmd_serr_en = 0, mcp_en = 0, serr_rx_en = 0;
    logic [15:0] sts_clr = '0;
    logic [7:0]  ed_clr = '0;
    logic        err_addr_clr = 0;
    logic        perr_n, serr_n, mcp_req, data_drop, err_addr_vld;
    logic [15:0] status;
    logic [7:0]  err_det;
    logic [31:0] err_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_sts = '0;
    logic [7:0]  m_ed = '0;
    logic [31:0] m_addr = '0, m_last = '0;
    bit          m_vld = 0;

    always #5 clk = ~clk;

    pci_perr_unit dut_i (
        .clk(clk), .rst(rst), .addr_phase(addr_phase), .data_phase(data_phase),
        .ad(ad), .cbe(cbe), .par(par), .is_master(is_master), .is_write(is_write),
        .perr_in_n(perr_in_n), .serr_in_n(serr_in_n),
        .cmd_perr_resp(cmd_perr_resp), .cmd_serr_en(cmd_serr_en),
        .mcp_en(mcp_en), .serr_rx_en(serr_rx_en),
        .sts_clr(sts_clr), .ed_clr(ed_clr), .err_addr_clr(err_addr_clr),
        .perr_n(perr_n), .serr_n(serr_n), .mcp_req(mcp_req), .data_drop(data_drop),
        .status(status), .err_det(err_det), .err_addr(err_addr), .err_addr_vld(err_addr_vld)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_en(input bit cpr, input bit cse, input bit men, input bit rxe);
        @(negedge clk);
        cmd_perr_resp = cpr; cmd_serr_en = cse; mcp_en = men; serr_rx_en = rxe;
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk("R10", "idle perr_n", perr_n, 1);
        chk("R10", "idle serr_n", serr_n, 1);
        chk("R10", "idle mcp_req", mcp_req, 0);
        chk("R6", "idle data_drop", data_drop, 0);
    endtask

    // one phase, its parity clock, the result clock, then an idle clock
    task automatic run_phase(input bit isaddr, input bit mst, input bit wr,
                             input bit bad, input logic [15:0] clr);
        logic [31:0] a;
        logic [3:0]  b;
        bit recv, err, e_serr, e_perr, e_mdpe, e_tperr, e_mcp;
        logic [15:0] set;
        a = $urandom; b = 4'($urandom);
        @(negedge clk);
        addr_phase = isaddr; data_phase = !isaddr; ad = a; cbe = b;
        is_master = mst; is_write = wr;
        @(negedge clk);
        addr_phase = 0; data_phase = 0;
        par = (^{a, b}) ^ bad;
        sts_clr = clr;
        recv    = isaddr || (mst && !wr) || (!mst && wr);
        err     = bad && recv;
        e_serr  = isaddr && err && !mst && cmd_serr_en && cmd_perr_resp;
        e_perr  = !isaddr && err && cmd_perr_resp;
        e_mdpe  = !isaddr && err && mst && cmd_perr_resp;
        e_tperr = !isaddr && err && !mst;
        e_mcp   = mcp_en && (e_serr || e_perr || e_mdpe);
        set = '0;
        set[15] = err; set[14] = e_serr; set[8] = e_mdpe;
        if (isaddr) m_last = a;
        m_sts = (m_sts & ~clr) | set;
        if (e_tperr) m_ed[6] = 1'b1;
        @(negedge clk);
        sts_clr = '0;
        chk("R3", "serr_n", serr_n, !e_serr);
        chk("R4", "perr_n", perr_n, !e_perr);
        chk("R10", "mcp_req", mcp_req, e_mcp);
        chk("R6", "data_drop", data_drop, e_tperr);
        chk("R2", "status", status, m_sts);
        chk("R6", "err_det", err_det, m_ed);
        idle_chk();
    endtask

    // other agent pulls PERR# for one clock, interpreted by the last data phase role
    task automatic perr_in_evt(input bit mst, input bit wr);
        bit mwr, trd, mdpe;
        mwr  = mst && wr;
        trd  = !mst && !wr;
        mdpe = mwr && cmd_perr_resp;
        @(negedge clk);
        perr_in_n = 0;
        if (mwr) begin m_sts[15] = 1'b1; if (mdpe) m_sts[8] = 1'b1; end
        if (trd && !m_vld) begin m_vld = 1; m_addr = m_last; end
        @(negedge clk);
        perr_in_n = 1;
        chk("R5", "status after PERR# in", status, m_sts);
        chk("R5", "own perr_n", perr_n, 1);
        chk("R10", "mcp after PERR# in", mcp_req, mcp_en && (mdpe || trd));
        chk("R7", "err_addr_vld", err_addr_vld, m_vld);
        if (m_vld) chk("R7", "err_addr", err_addr, m_addr);
        idle_chk();
    endtask

    task automatic ext_serr();
        bit rec;
        rec = serr_rx_en;
        @(negedge clk);
        serr_in_n = 0;
        if (rec) m_ed[7] = 1'b1;
        @(negedge clk);
        serr_in_n = 1;
        chk("R9", "err_det after SERR# in", err_det, m_ed);
        chk("R10", "mcp after SERR# in", mcp_req, mcp_en && rec);
        idle_chk();
    endtask

    task automatic clr_regs(input logic [15:0] sm, input logic [7:0] em, input bit ac);
        @(negedge clk);
        sts_clr = sm; ed_clr = em; err_addr_clr = ac;
        m_sts &= ~sm; m_ed &= ~em;
        if (ac) m_vld = 0;
        @(negedge clk);
        sts_clr = '0; ed_clr = '0; err_addr_clr = 0;
        chk("R11", "status after clear", status, m_sts);
        chk("R11", "err_det after clear", err_det, m_ed);
        chk("R8", "err_addr_vld after clear", err_addr_vld, m_vld);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "perr_n", perr_n, 1);
        chk("R1", "serr_n", serr_n, 1);
        chk("R1", "mcp_req", mcp_req, 0);
        chk("R1", "status", status, 0);
        chk("R1", "err_det", err_det, 0);
        chk("R1", "err_addr_vld", err_addr_vld, 0);

        // R3: target address error with both enables, then with SERR# disabled
        set_en(1, 1, 1, 0);
        run_phase(1, 0, 0, 1, '0);
        clr_regs(16'hFFFF, 8'hFF, 1);
        set_en(1, 0, 1, 0);
        run_phase(1, 0, 1, 1, '0);
        chk("R3", "bit14 stays clear", status[14], 0);
        // R2: master address error, enables off, bit 15 still sets
        set_en(0, 0, 0, 0);
        run_phase(1, 1, 0, 1, '0);
        chk("R2", "bit15 with enables off", status[15], 1);
        clr_regs(16'hFFFF, 8'hFF, 1);

        // R4 master read data error
        set_en(1, 0, 1, 0);
        run_phase(0, 1, 0, 1, '0);
        chk("R4", "bit8 set", status[8], 1);
        clr_regs(16'hFFFF, 8'hFF, 0);
        set_en(0, 0, 1, 0);
        run_phase(0, 1, 0, 1, '0);
        chk("R4", "bit8 clear without resp", status[8], 0);

        // R6 target write data error, with and without response
        set_en(0, 0, 1, 0);
        run_phase(0, 0, 1, 1, '0);
        set_en(1, 0, 1, 0);
        run_phase(0, 0, 1, 1, '0);
        clr_regs(16'hFFFF, 8'hFF, 0);

        // R12 transmit-side data never checked
        run_phase(0, 1, 1, 1, '0);
        run_phase(0, 0, 0, 1, '0);
        chk("R12", "status after transmit errors", status, 0);

        // R5 target reports PERR# on master write
        run_phase(0, 1, 1, 0, '0);
        perr_in_evt(1, 1);

        // R7/R8 capture on target read, hold, then release and recapture
        run_phase(1, 0, 0, 0, '0);
        run_phase(0, 0, 0, 0, '0);
        perr_in_evt(0, 0);
        chk("R7", "first capture valid", err_addr_vld, 1);
        run_phase(1, 0, 0, 0, '0);
        run_phase(0, 0, 0, 0, '0);
        perr_in_evt(0, 0);
        chk("R8", "address held", err_addr, m_addr);
        clr_regs('0, '0, 1);
        perr_in_evt(0, 0);
        chk("R8", "recaptured newest address", err_addr, m_last);

        // R9 external SERR#
        set_en(1, 1, 1, 0);
        ext_serr();
        chk("R9", "ignored without rx enable", err_det[7], 0);
        set_en(1, 1, 1, 1);
        ext_serr();

        // R11 clear and set in the same clock: set wins
        clr_regs(16'hFFFF, 8'hFF, 1);
        run_phase(0, 1, 0, 0, '0);
        run_phase(0, 1, 0, 1, '0);
        run_phase(0, 1, 0, 1, 16'hFFFF);
        chk("R11", "bit15 survives clear", status[15], 1);
        chk("R11", "status after coincident clear", status, m_sts);

        // random mix
        for (int i = 0; i < 250; i++) begin
            int op;
            set_en(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            op = $urandom % 5;
            case (op)
                0: run_phase(1, 1'($urandom), 1'($urandom), 1'($urandom),
                             ($urandom % 4 == 0) ? 16'($urandom) : 16'h0);
                1: run_phase(0, 1'($urandom), 1'($urandom), 1'($urandom),
                             ($urandom % 4 == 0) ? 16'($urandom) : 16'h0);
                2: begin
                    bit m, w;
                    m = 1'($urandom); w = 1'($urandom);
                    if ($urandom % 2 == 0) run_phase(1, m, w, 0, '0);
                    run_phase(0, m, w, 0, '0);
                    perr_in_evt(m, w);
                end
                3: ext_serr();
                default: clr_regs(16'($urandom), 8'($urandom), 1'($urandom));
            endcase
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule